// File: doc/BRIEF.md
# Saturating Output Watchdog

This block guards a board's drive outputs against a host that has stopped talking to it. A 7-bit count advances once for every period pulse that the PWM timebase produces. When the count reaches its ceiling it stays there. If the watchdog has been armed, it then raises a request that puts the digital outputs and the PWM outputs into high impedance. With a period pulse of roughly 51.2 µs, the outputs float about 6.5 ms after the host's last refresh.

The host refreshes the watchdog through a register write strobe that carries one refresh bit. A strobe with that bit at 1 clears the count and arms the watchdog. Once armed, the watchdog stays armed until a device reset; no write can disarm it. While the watchdog is unarmed, the count still runs up to its ceiling, but the float request stays low. The current count is available on a plain status output so the host can read it back.

The pulse, strobe and status pins are plain control signals with no handshake. A strobe is taken in the cycle it is high.

Top module: `wdg_guard`

## Requirements
- R1: After reset `count_o` is 0, the watchdog is unarmed and `float_o` is 0. A later reset returns the block to this state.
- R2: Consider a clock edge where `tick_i` is 1, there is no refresh, and `count_o` is below 127. After that edge `count_o` is one higher.
- R3: When `count_o` is 127, a `tick_i` pulse without a refresh leaves it at 127. The count never wraps.
- R4: A refresh is a cycle with `wr_stb_i`=1 and `kick_i`=1. After the edge that takes a refresh, `count_o` is 0 and the watchdog is armed.
- R5: If a refresh and a `tick_i` pulse fall in the same cycle, the refresh wins and `count_o` becomes 0.
- R6: A strobe with `kick_i`=0 changes neither the count nor the armed state. This is seen on `count_o` and `float_o`.
- R7: `float_o` is 1 exactly when the watchdog is armed and `count_o` is 127. It rises in the same cycle that `count_o` first shows 127.
- R8: Once armed, the watchdog stays armed until reset. When unarmed, `float_o` is 0 even with the count at 127.
- R9: In a cycle with no `tick_i` pulse and no refresh, `count_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse for each PWM period overflow |
| wr_stb_i | input | 1 | Write strobe for the watchdog control bit |
| kick_i | input | 1 | Refresh bit, taken only when `wr_stb_i` is 1 |
| float_o | output | 1 | Request to tristate the digital and PWM outputs |
| count_o | output | 7 | Current watchdog count |

## Verification
The hardest case to reach is a refresh and a period pulse arriving in the same cycle while the armed count sits at its ceiling with `float_o` high. This case checks both the priority rule and that the float request drops at once. To get there, the bench first arms the watchdog and steps the count to 127 with back-to-back pulses. It then drives strobe, refresh bit and pulse together in one cycle. A second hard case is stickiness across a refresh-free saturation, which the bench reaches by letting the count run out twice after a single arming.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  parameter int unsigned WDG_CNT_W = 7;
  typedef logic [WDG_CNT_W-1:0] wdg_cnt_t;
endpackage

// File: rtl/wdg_sat_counter.sv
module wdg_sat_counter #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         at_top
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  assign at_top = (cnt_q == TOP);
  assign cnt    = cnt_q;

  // clear has priority over step; step stops at the ceiling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step && !at_top) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_arm_latch.sv
module wdg_arm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic armed
);
  logic armed_q;

  // set-only flag: only reset clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (set) begin
      armed_q <= 1'b1;
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/wdg_float_dec.sv
module wdg_float_dec (
  input  logic armed,
  input  logic at_top,
  output logic float_req
);
  assign float_req = armed & at_top;
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard #(
  parameter int unsigned CNT_W = wdg_pkg::WDG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_stb_i,
  input  logic             kick_i,
  output logic             float_o,
  output logic [CNT_W-1:0] count_o
);
  logic             kick_go;
  logic             armed_q;
  logic             at_top;
  logic [CNT_W-1:0] cnt;

  assign kick_go = wr_stb_i & kick_i;

  wdg_sat_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (kick_go),
    .step   (tick_i),
    .cnt    (cnt),
    .at_top (at_top)
  );

  wdg_arm_latch u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (kick_go),
    .armed (armed_q)
  );

  wdg_float_dec u_dec (
    .armed     (armed_q),
    .at_top    (at_top),
    .float_req (float_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_stb_i,
  input logic             kick_i,
  input logic             float_o,
  input logic [CNT_W-1:0] count_o,
  input logic             armed_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic refresh;
  assign refresh = wr_stb_i & kick_i;

  // R2
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !refresh && count_o != TOP) |=> count_o == $past(count_o) + 1'b1);
  // R3
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !refresh && count_o == TOP) |=> count_o == TOP);
  // R4 and R5
  p_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (count_o == '0 && armed_q));
  // R7
  p_float_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    float_o |-> count_o == TOP);
  // R8
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R8
  p_quiet_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !float_o);
  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !refresh) |=> $stable(count_o));
endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .wr_stb_i (wr_stb_i),
  .kick_i   (kick_i),
  .float_o  (float_o),
  .count_o  (count_o),
  .armed_q  (armed_q)
);

// File: tb/wdg_guard_bench.sv
module wdg_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_stb_i = 1'b0;
  logic       kick_i = 1'b0;
  logic       float_o;
  logic [6:0] count_o;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit m_arm = 1'b0;

  always #4 clk = ~clk;

  wdg_guard u_wdg_guard (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_stb_i(wr_stb_i),
    .kick_i(kick_i), .float_o(float_o), .count_o(count_o)
  );

  task automatic compare(input string tag);
    int exp_f;
    exp_f = (m_arm && m_cnt == 127) ? 1 : 0;
    checks++;
    if (int'(count_o) != m_cnt || int'(float_o) != exp_f) begin
      errors++;
      $display("FAIL %s count=%0d float=%0d expected count=%0d float=%0d",
               tag, count_o, float_o, m_cnt, exp_f);
    end
  endtask

  // one clock: drive after falling edge, update model at rising edge, sample 2ns later
  task automatic cyc(input bit t, input bit w, input bit k, input string tag);
    @(negedge clk);
    tick_i = t; wr_stb_i = w; kick_i = k;
    @(posedge clk);
    if (w && k) begin m_cnt = 0; m_arm = 1'b1; end
    else if (t && m_cnt < 127) m_cnt = m_cnt + 1;
    #2;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 0; wr_stb_i = 0; kick_i = 0;
    m_cnt = 0; m_arm = 1'b0;
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R2");
    cyc(0, 1, 0, "R6");
    cyc(0, 0, 0, "R9");
    cyc(1, 1, 0, "R6");
    for (int i = 0; i < 130; i++) cyc(1, 0, 0, "R3");
    cyc(1, 0, 0, "R8");
    cyc(0, 1, 1, "R4");
    for (int i = 0; i < 126; i++) cyc(1, 0, 0, "R2");
    cyc(1, 0, 0, "R7");
    cyc(1, 0, 0, "R3");
    cyc(0, 1, 0, "R6");
    cyc(1, 1, 1, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R9");
    for (int i = 0; i < 130; i++) cyc(1, 0, 0, "R8");
    cyc(0, 1, 1, "R4");
    for (int i = 0; i < 40; i++) cyc(i % 3 == 0, 0, 0, "R9");
    do_reset();
    for (int i = 0; i < 129; i++) cyc(1, 0, 0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout count=%0d expected completion", count_o);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule